// File: doc/BRIEF.md
# Pixel Clock Divider Search Engine

This block picks the reference divider M and the feedback multiplier N for a pixel-clock synthesizer, so that f_ref*N/M comes as close as possible to a requested frequency. All frequencies are unsigned integers in kHz. On a start pulse the engine captures its inputs. It clamps the request to a window: the lower edge is a minimum VCO frequency and the upper edge is a ceiling chosen by a colour-depth select. The synthesizer has no post-divider, so the clamped value is the VCO target.

The engine then walks M upward from 1 and works out the rounded N for each M with a shared serial divider. It keeps the closest candidate. At the end it encodes the winner into three register bytes and reports the frequency that setting gives. A family select sets the M and N ceilings and the byte layout. Programming the bytes into the synthesizer and waiting for lock belong to the surrounding logic.

Top module: `pll_div_search`

## Requirements
- R1: While reset is held and after its release until the first search completes, busy, done and no_fit are 0 and m_byte, n_byte, x_byte and fout_khz are all 0.
- R2: A request below min_vco_khz is raised to min_vco_khz before the search.
- R3: After the lower clamp, the target is capped at a ceiling picked by depth_sel: 0 selects max8_khz, 1 selects max16_khz, 2 and 3 select max24_khz.
- R4: fam_sel sets the limits (M_max, N_max): code 0 gives (32, 128), code 1 gives (64, 128), codes 2 and 3 give (64, 2048).
- R5: For each M the candidate N is floor((2*target*M + f_ref) / (2*f_ref)), which is the target*M/f_ref ratio rounded half up. A candidate with N = 0 or N > N_max is discarded. f_ref = 0 yields no candidate.
- R6: Odd M values above M_max/2 are never evaluated.
- R7: The winner has the smallest |target - f_ref*N/M|, compared exactly. A later M with an equal error does not replace an earlier one.
- R8: The prescale flag P is 1 when the winning M exceeds M_max/2. m_byte is M/2-1 when P is 1 and M-1 when P is 0.
- R9: For fam_sel 0 or 1, n_byte is {P, (N-1)[6:0]} with P in bit 7, and x_byte is 0.
- R10: For fam_sel 2 or 3, n_byte is (N-1)[7:0], and x_byte has P in bit 7, (N-1)[10:8] in bits 6:4 and zeros in bits 3:0.
- R11: fout_khz equals floor(f_ref*N/M) for the winning pair.
- R12: When no candidate survives, no_fit is 1 and all four result outputs are 0. Otherwise no_fit is 0.
- R13: busy rises in the cycle after an accepted start. done is a one-cycle pulse, with busy low, in the cycle the results update. A start while busy is ignored. The results hold until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Start a search (taken only when idle) |
| fam_sel | input | 2 | Chip family: limits and byte layout |
| depth_sel | input | 2 | Colour depth: picks the upper clamp |
| req_khz | input | FW | Requested pixel frequency |
| fref_khz | input | FW | Reference frequency |
| min_vco_khz | input | FW | Lower clamp |
| max8_khz | input | FW | Ceiling for depth code 0 |
| max16_khz | input | FW | Ceiling for depth code 1 |
| max24_khz | input | FW | Ceiling for depth codes 2 and 3 |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| no_fit | output | 1 | No valid divider pair found |
| m_byte | output | 8 | Encoded reference divider |
| n_byte | output | 8 | Encoded multiplier low byte |
| x_byte | output | 8 | Prescale flag and multiplier high bits |
| fout_khz | output | FW | Achieved frequency |

## Verification
Each evaluated M costs one launch cycle, the serial divider's DW step cycles and one cycle to take in the quotient. Skipped odd M values cost one cycle each. The final frequency division adds roughly another DW+2 cycles. Because of this, the latency depends on the family and on the inputs. The bench therefore does not predict a cycle count. It drives the inputs on falling edges and polls done on falling edges, up to a bound. It compares every result port in the cycle where done is seen, and checks one falling edge later that done has dropped. busy is checked at the first falling edge after the start pulse. A start given mid-search is checked by confirming that the results match the inputs captured at the original start.

// File: rtl/pllsrch_pkg.sv
package pllsrch_pkg;

  // search controller states
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_NWAIT = 2'd2,
    ST_FWAIT = 2'd3
  } srch_st_t;

  // encoded synthesizer register bytes
  typedef struct packed {
    logic [7:0] m;
    logic [7:0] n;
    logic [7:0] x;
  } pll_code_t;

endpackage

// File: rtl/pllsrch_limits.sv
module pllsrch_limits #(
  parameter int FW      = 20,
  parameter int MW      = 7,
  parameter int NW      = 12,
  parameter int M_SMALL = 32,
  parameter int M_LARGE = 64,
  parameter int N_SMALL = 128,
  parameter int N_LARGE = 2048
) (
  input  logic [1:0]    fam_sel,
  input  logic [1:0]    depth_sel,
  input  logic [FW-1:0] req_khz,
  input  logic [FW-1:0] min_vco_khz,
  input  logic [FW-1:0] max8_khz,
  input  logic [FW-1:0] max16_khz,
  input  logic [FW-1:0] max24_khz,
  output logic [FW-1:0] target_khz,
  output logic [MW-1:0] m_max,
  output logic [NW-1:0] n_max
);

  logic [FW-1:0] ceil_khz;
  logic [FW-1:0] floor_done;

  // ceiling per colour depth
  always_comb begin
    case (depth_sel)
      2'd0:    ceil_khz = max8_khz;
      2'd1:    ceil_khz = max16_khz;
      default: ceil_khz = max24_khz;
    endcase
  end

  // raise to the VCO floor first, then cap
  always_comb begin
    floor_done = (req_khz < min_vco_khz) ? min_vco_khz : req_khz;
    target_khz = (floor_done > ceil_khz) ? ceil_khz : floor_done;
  end

  // family ceilings
  always_comb begin
    m_max = (fam_sel == 2'd0) ? MW'(M_SMALL) : MW'(M_LARGE);
    n_max = fam_sel[1] ? NW'(N_LARGE) : NW'(N_SMALL);
  end

endmodule

// File: rtl/pllsrch_div.sv
module pllsrch_div #(
  parameter int DW = 33
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic [DW-1:0] quo,
  output logic          done
);

  localparam int CW = $clog2(DW + 1);

  logic [DW:0]   rem_q, rem_d;
  logic [DW-1:0] quo_q, quo_d;
  logic [DW-1:0] dvs_q, dvs_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic          done_q, done_d;

  logic [DW:0]   trial;
  logic          fits;

  // one restoring step per cycle
  always_comb begin
    trial = {rem_q[DW-1:0], quo_q[DW-1]};
    fits  = (trial >= {1'b0, dvs_q});
  end

  always_comb begin
    rem_d  = rem_q;
    quo_d  = quo_q;
    dvs_d  = dvs_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    done_d = 1'b0;
    if (go) begin
      rem_d = '0;
      quo_d = dividend;
      dvs_d = divisor;
      cnt_d = CW'(DW);
      run_d = 1'b1;
    end else if (run_q) begin
      rem_d  = fits ? (trial - {1'b0, dvs_q}) : trial;
      quo_d  = {quo_q[DW-2:0], fits};
      cnt_d  = cnt_q - CW'(1);
      run_d  = (cnt_q != CW'(1));
      done_d = (cnt_q == CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      dvs_q  <= dvs_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  assign quo  = quo_q;
  assign done = done_q;

endmodule

// File: rtl/pllsrch_enc.sv
module pllsrch_enc
  import pllsrch_pkg::*;
#(
  parameter int MW = 7,
  parameter int NW = 12
) (
  input  logic          new_fam,
  input  logic [MW-1:0] m_best,
  input  logic [MW-1:0] m_max,
  input  logic [NW-1:0] n_best,
  output pll_code_t     code
);

  logic          pre;
  logic [MW-1:0] m_base;
  logic [MW-1:0] m_code;
  logic [NW-1:0] n_code;

  always_comb begin
    pre    = (m_best > (m_max >> 1));
    m_base = pre ? (m_best >> 1) : m_best;
    m_code = m_base - MW'(1);
    n_code = n_best - NW'(1);
  end

  // layout picked by family generation
  generate
    if (NW >= 11) begin : g_wide
      always_comb begin
        code.m = 8'(m_code);
        if (new_fam) begin
          code.n = n_code[7:0];
          code.x = {pre, n_code[10:8], 4'b0000};
        end else begin
          code.n = {pre, n_code[6:0]};
          code.x = 8'h00;
        end
      end
    end else begin : g_narrow
      always_comb begin
        code.m = 8'(m_code);
        code.n = {pre, n_code[6:0]};
        code.x = {7'b0, new_fam & 1'b0};
      end
    end
  endgenerate

endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pllsrch_pkg::*;
#(
  parameter int FW = 20,
  parameter int MW = 7,
  parameter int NW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    fam_sel,
  input  logic [1:0]    depth_sel,
  input  logic [FW-1:0] req_khz,
  input  logic [FW-1:0] fref_khz,
  input  logic [FW-1:0] min_vco_khz,
  input  logic [FW-1:0] max8_khz,
  input  logic [FW-1:0] max16_khz,
  input  logic [FW-1:0] max24_khz,
  output logic          busy,
  output logic          done,
  output logic          no_fit,
  output logic [7:0]    m_byte,
  output logic [7:0]    n_byte,
  output logic [7:0]    x_byte,
  output logic [FW-1:0] fout_khz
);

  localparam int DW = FW + NW + 1;   // divider width
  localparam int EW = FW + NW + 1;   // error numerator width
  localparam int PW = EW + MW;       // cross product width

  // reset: asynchronous assert, synchronous release
  logic rs1_q, rs2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  logic rst_i_n;
  assign rst_i_n = rs2_q;

  // clamped target and family limits
  logic [FW-1:0] lim_target;
  logic [MW-1:0] lim_mmax;
  logic [NW-1:0] lim_nmax;

  pllsrch_limits #(.FW(FW), .MW(MW), .NW(NW)) u_lim (
    .fam_sel     (fam_sel),
    .depth_sel   (depth_sel),
    .req_khz     (req_khz),
    .min_vco_khz (min_vco_khz),
    .max8_khz    (max8_khz),
    .max16_khz   (max16_khz),
    .max24_khz   (max24_khz),
    .target_khz  (lim_target),
    .m_max       (lim_mmax),
    .n_max       (lim_nmax)
  );

  // state
  srch_st_t      st_q, st_d;
  logic [MW-1:0] m_q, m_d;
  logic          found_q, found_d;
  logic [MW-1:0] best_m_q, best_m_d;
  logic [NW-1:0] best_n_q, best_n_d;
  logic [EW-1:0] best_e_q, best_e_d;
  logic [FW-1:0] target_q, target_d;
  logic [FW-1:0] fref_q, fref_d;
  logic [MW-1:0] mmax_q, mmax_d;
  logic [NW-1:0] nmax_q, nmax_d;
  logic [1:0]    fam_q, fam_d;
  pll_code_t     code_q, code_d;
  logic [FW-1:0] fout_q, fout_d;
  logic          nofit_q, nofit_d;
  logic          done_q, done_d;

  // shared divider
  logic          div_go;
  logic [DW-1:0] div_a, div_b;
  logic [DW-1:0] div_q;
  logic          div_done;

  pllsrch_div #(.DW(DW)) u_div (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .go       (div_go),
    .dividend (div_a),
    .divisor  (div_b),
    .quo      (div_q),
    .done     (div_done)
  );

  // encoder on the kept winner
  pll_code_t enc_code;

  pllsrch_enc #(.MW(MW), .NW(NW)) u_enc (
    .new_fam (fam_q[1]),
    .m_best  (best_m_q),
    .m_max   (mmax_q),
    .n_best  (best_n_q),
    .code    (enc_code)
  );

  // candidate evaluation
  logic [NW-1:0] n_cand;
  logic          n_ok;
  logic [EW-1:0] lhs_f, rhs_f, err;
  logic [PW-1:0] cross_new, cross_old;
  logic          better;
  logic          m_skip;
  logic          m_past;

  always_comb begin
    n_cand    = div_q[NW-1:0];
    n_ok      = (div_q != '0) && (div_q <= DW'(nmax_q));
    lhs_f     = EW'(target_q) * EW'(m_q);
    rhs_f     = EW'(fref_q) * EW'(n_cand);
    err       = (lhs_f >= rhs_f) ? (lhs_f - rhs_f) : (rhs_f - lhs_f);
    cross_new = PW'(err) * PW'(best_m_q);
    cross_old = PW'(best_e_q) * PW'(m_q);
    better    = !found_q || (cross_new < cross_old);
    m_past    = (m_q > mmax_q);
    m_skip    = (m_q > (mmax_q >> 1)) && m_q[0];
  end

  // next state
  always_comb begin
    st_d     = st_q;
    m_d      = m_q;
    found_d  = found_q;
    best_m_d = best_m_q;
    best_n_d = best_n_q;
    best_e_d = best_e_q;
    target_d = target_q;
    fref_d   = fref_q;
    mmax_d   = mmax_q;
    nmax_d   = nmax_q;
    fam_d    = fam_q;
    code_d   = code_q;
    fout_d   = fout_q;
    nofit_d  = nofit_q;
    done_d   = 1'b0;
    div_go   = 1'b0;
    div_a    = (DW'(target_q) * DW'(m_q) << 1) + DW'(fref_q);
    div_b    = DW'(fref_q) << 1;

    case (st_q)
      ST_IDLE: begin
        if (start) begin
          target_d = lim_target;
          fref_d   = fref_khz;
          mmax_d   = lim_mmax;
          nmax_d   = lim_nmax;
          fam_d    = fam_sel;
          m_d      = MW'(1);
          found_d  = 1'b0;
          best_m_d = MW'(1);
          best_n_d = NW'(1);
          best_e_d = '0;
          st_d     = ST_SCAN;
        end
      end

      ST_SCAN: begin
        if (m_past) begin
          if (found_q) begin
            div_go = 1'b1;
            div_a  = DW'(fref_q) * DW'(best_n_q);
            div_b  = DW'(best_m_q);
            st_d   = ST_FWAIT;
          end else begin
            code_d  = '0;
            fout_d  = '0;
            nofit_d = 1'b1;
            done_d  = 1'b1;
            st_d    = ST_IDLE;
          end
        end else if (m_skip) begin
          m_d = m_q + MW'(1);
        end else begin
          div_go = 1'b1;
          st_d   = ST_NWAIT;
        end
      end

      ST_NWAIT: begin
        if (div_done) begin
          if (n_ok && better) begin
            found_d  = 1'b1;
            best_m_d = m_q;
            best_n_d = n_cand;
            best_e_d = err;
          end
          m_d  = m_q + MW'(1);
          st_d = ST_SCAN;
        end
      end

      ST_FWAIT: begin
        if (div_done) begin
          code_d  = enc_code;
          fout_d  = div_q[FW-1:0];
          nofit_d = 1'b0;
          done_d  = 1'b1;
          st_d    = ST_IDLE;
        end
      end

      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q     <= ST_IDLE;
      m_q      <= '0;
      found_q  <= 1'b0;
      best_m_q <= '0;
      best_n_q <= '0;
      best_e_q <= '0;
      target_q <= '0;
      fref_q   <= '0;
      mmax_q   <= '0;
      nmax_q   <= '0;
      fam_q    <= '0;
      code_q   <= '0;
      fout_q   <= '0;
      nofit_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      m_q      <= m_d;
      found_q  <= found_d;
      best_m_q <= best_m_d;
      best_n_q <= best_n_d;
      best_e_q <= best_e_d;
      target_q <= target_d;
      fref_q   <= fref_d;
      mmax_q   <= mmax_d;
      nmax_q   <= nmax_d;
      fam_q    <= fam_d;
      code_q   <= code_d;
      fout_q   <= fout_d;
      nofit_q  <= nofit_d;
      done_q   <= done_d;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
  assign no_fit   = nofit_q;
  assign m_byte   = code_q.m;
  assign n_byte   = code_q.n;
  assign x_byte   = code_q.x;
  assign fout_khz = fout_q;

endmodule

// File: rtl/pllsrch_chk.sv
module pllsrch_chk #(
  parameter int FW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          no_fit,
  input logic [7:0]    m_byte,
  input logic [7:0]    n_byte,
  input logic [7:0]    x_byte,
  input logic [FW-1:0] fout_khz,
  input logic [1:0]    fam_q
);

  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R13
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R13
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done) |=> busy);

  // R13
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(fout_khz) && $stable(m_byte) && $stable(n_byte) && $stable(x_byte)));

  // R12
  nofit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    no_fit |-> (m_byte == 8'h00 && n_byte == 8'h00 && x_byte == 8'h00 && fout_khz == '0));

  // R9
  old_extra_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fam_q[1]) |-> (x_byte == 8'h00));

  // R10
  new_extra_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (x_byte[3:0] == 4'h0));

  // R8
  mcode_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (m_byte[7:5] == 3'b000));

endmodule

bind pll_div_search pllsrch_chk #(.FW(FW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .no_fit   (no_fit),
  .m_byte   (m_byte),
  .n_byte   (n_byte),
  .x_byte   (x_byte),
  .fout_khz (fout_khz),
  .fam_q    (fam_q)
);

// File: tb/tb_pll_div_search.sv
module tb_pll_div_search;

  localparam int FW = 20;
  localparam time CLK_PERIOD = 10ns;
  localparam int WAIT_LIMIT = 6000;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [1:0]    fam_sel, depth_sel;
  logic [FW-1:0] req_khz, fref_khz, min_vco_khz, max8_khz, max16_khz, max24_khz;
  logic          busy, done, no_fit;
  logic [7:0]    m_byte, n_byte, x_byte;
  logic [FW-1:0] fout_khz;

  int total = 0;
  int bad   = 0;

  pll_div_search #(.FW(FW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .fam_sel(fam_sel), .depth_sel(depth_sel),
    .req_khz(req_khz), .fref_khz(fref_khz), .min_vco_khz(min_vco_khz),
    .max8_khz(max8_khz), .max16_khz(max16_khz), .max24_khz(max24_khz),
    .busy(busy), .done(done), .no_fit(no_fit),
    .m_byte(m_byte), .n_byte(n_byte), .x_byte(x_byte), .fout_khz(fout_khz)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference model built from the requirements
  task automatic model(input int fam, input int depth, input longint req, input longint fref,
                       input longint mn, input longint a8, input longint a16, input longint a24,
                       output logic [7:0] em, output logic [7:0] en, output logic [7:0] ex,
                       output longint ef, output bit enf);
    longint t, mx, n, e, bm, bn, be;
    int mmax, nmax;
    bit found, pre;
    logic [11:0] nm1;
    mx = (depth == 0) ? a8 : (depth == 1) ? a16 : a24;
    t = (req < mn) ? mn : req;
    if (t > mx) t = mx;
    mmax = (fam == 0) ? 32 : 64;
    nmax = (fam >= 2) ? 2048 : 128;
    found = 0; bm = 1; bn = 1; be = 0;
    for (int m = 1; m <= mmax; m++) begin
      if (m > mmax / 2 && (m % 2) == 1) continue;
      if (fref == 0) continue;
      n = (2 * t * m + fref) / (2 * fref);
      if (n < 1 || n > nmax) continue;
      e = t * m - fref * n;
      if (e < 0) e = -e;
      if (!found || e * bm < be * m) begin
        found = 1; bm = m; bn = n; be = e;
      end
    end
    if (!found) begin
      em = 0; en = 0; ex = 0; ef = 0; enf = 1;
    end else begin
      pre = (bm > mmax / 2);
      em  = pre ? 8'(bm / 2 - 1) : 8'(bm - 1);
      nm1 = 12'(bn - 1);
      if (fam < 2) begin
        en = {pre, nm1[6:0]};
        ex = 8'h00;
      end else begin
        en = nm1[7:0];
        ex = {pre, nm1[10:8], 4'h0};
      end
      ef  = fref * bn / bm;
      enf = 0;
    end
  endtask

  task automatic drive(int fam, int depth, int req, int fref, int mn, int a8, int a16, int a24);
    fam_sel     = 2'(fam);
    depth_sel   = 2'(depth);
    req_khz     = FW'(req);
    fref_khz    = FW'(fref);
    min_vco_khz = FW'(mn);
    max8_khz    = FW'(a8);
    max16_khz   = FW'(a16);
    max24_khz   = FW'(a24);
  endtask

  task automatic wait_done(string tag);
    int w = 0;
    while (!done && w < WAIT_LIMIT) begin
      @(negedge clk);
      w++;
    end
    if (!done) chk(0, tag, "watchdog expired waiting for done", w, WAIT_LIMIT);
  endtask

  // one search; tag names the requirement under test
  task automatic run_case(string tag, int fam, int depth, int req, int fref,
                          int mn, int a8, int a16, int a24, bit poke_busy);
    logic [7:0] em, en, ex;
    longint ef;
    bit enf;
    string ftag;
    model(fam, depth, req, fref, mn, a8, a16, a24, em, en, ex, ef, enf);
    drive(fam, depth, req, fref, mn, a8, a16, a24);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke_busy) begin
      // R13: busy one cycle after start; a start mid-search is ignored
      chk(busy == 1'b1, "R13", "busy after start", busy, 1);
      repeat (5) @(negedge clk);
      drive((fam + 1) % 4, (depth + 1) % 4, req / 2 + 1, fref + 777, mn, a8, a16, a24);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_done(tag);
    ftag = (fam < 2) ? "R9" : "R10";
    chk(no_fit == enf, {tag, " R12"}, "no_fit", no_fit, enf);
    chk(m_byte == em, {tag, " R8"}, "m_byte", m_byte, em);
    chk(n_byte == en, {tag, " ", ftag}, "n_byte", n_byte, en);
    chk(x_byte == ex, {tag, " ", ftag}, "x_byte", x_byte, ex);
    chk(longint'(fout_khz) == ef, {tag, " R11"}, "fout_khz", fout_khz, ef);
    chk(busy == 1'b0, {tag, " R13"}, "busy with done", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R13"}, "done pulse width", done, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    start = 1'b0;
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 0 && done == 0 && no_fit == 0, "R1", "flags in reset", {busy, done, no_fit}, 0);
    chk(m_byte == 0 && n_byte == 0 && x_byte == 0 && fout_khz == 0, "R1", "results in reset",
        fout_khz, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 0 && done == 0 && fout_khz == 0, "R1", "idle after release", busy, 0);

    // R2: request below floor
    run_case("R2", 1, 0, 1000, 14318, 25000, 200000, 150000, 100000, 0);
    chk(fout_khz > 24000 && fout_khz < 26000, "R2", "fout near floor", fout_khz, 25000);
    // R3: ceiling per depth code
    run_case("R3", 2, 1, 500000, 14318, 12000, 200000, 80000, 60000, 0);
    run_case("R3", 1, 0, 500000, 14318, 12000, 90000, 80000, 60000, 0);
    run_case("R3", 2, 3, 500000, 14318, 12000, 200000, 80000, 60000, 0);
    // R6: exact fit at odd M=63 is skipped; M=64 wins with prescale
    run_case("R6", 1, 2, 1000, 63000, 500, 200000, 200000, 200000, 0);
    chk(m_byte == 8'd31, "R6", "m_byte even upper M", m_byte, 31);
    chk(n_byte == 8'h80, "R6", "n_byte prescale bit", n_byte, 128);
    chk(fout_khz == 984, "R6", "fout", fout_khz, 984);
    // R7: equal errors, first M kept (M=1, N=2)
    run_case("R7", 1, 2, 20000, 10000, 500, 200000, 200000, 200000, 0);
    chk(m_byte == 8'd0 && n_byte == 8'd1, "R7", "first exact pair kept", {m_byte, n_byte}, 1);
    // R10 and R5: large N on new family: N=2000, N-1=0x7CF
    run_case("R10", 2, 0, 200000, 100, 500, 200000, 200000, 200000, 0);
    chk(n_byte == 8'hCF && x_byte == 8'h70, "R10", "wide N split", {n_byte, x_byte}, 16'hCF70);
    // R4: same request on middle family: every N over 128
    run_case("R4", 1, 0, 200000, 100, 500, 200000, 200000, 200000, 0);
    chk(no_fit == 1'b1, "R4", "N ceiling 128", no_fit, 1);
    // R4: oldest family stops at M=32
    run_case("R4", 0, 2, 1000, 63000, 500, 200000, 200000, 200000, 0);
    // R12 and R5: all N round to zero; f_ref zero
    run_case("R12", 0, 2, 5000, 1048575, 1000, 200000, 200000, 200000, 0);
    chk(no_fit == 1'b1, "R12", "no candidate", no_fit, 1);
    run_case("R5", 3, 2, 50000, 0, 1000, 200000, 200000, 200000, 0);
    chk(no_fit == 1'b1, "R5", "zero reference", no_fit, 1);
    // R13: start while busy
    run_case("R13", 2, 1, 65000, 14318, 12000, 200000, 150000, 100000, 1);

    // random mix
    for (int k = 0; k < 28; k++) begin
      run_case("R5", int'($urandom % 4), int'($urandom % 4),
               1000 + int'($urandom % 300000), 5000 + int'($urandom % 45000),
               10000 + int'($urandom % 20000), 150000 + int'($urandom % 100000),
               80000 + int'($urandom % 100000), 40000 + int'($urandom % 80000), 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule